// File: doc/BRIEF.md
# Dual Calendar Alarm Comparator

This block keeps two alarm descriptions, each made of six bytes that mirror the seconds, minutes, hours, date, month and weekday fields of a BCD clock. On every one-second tick it compares each description against the live time supplied by an external timekeeper. In each alarm byte the top bit decides whether that field takes part in the comparison. The lower seven bits hold the value the field must equal. Only fields whose enable bit is set are compared, so an alarm can fire once a minute, once a day, on a given weekday, and so on.

A match on an armed alarm sets that alarm's status flag. Both alarms drive one shared active-low interrupt line, which behaves in one of two ways:
- In latched mode, the line stays low until software has cleared every flag.
- In periodic mode, each match produces a short fixed-width low pulse.

Software reaches the alarm bytes, a control register and a status register through a simple register read/write port. Flags are cleared by writing zero to them. When auto-clear is enabled, they are also cleared by a read of the status register. A new match always wins over a clear that lands in the same cycle.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset the interrupt output `irq_n` is high, the status register reads 0, and every alarm byte and the control register read 0.
- R2: Alarm 0 bytes sit at addresses 0..5 and alarm 1 bytes at 8..13, in the order second, minute, hour, date, month, weekday. The control register sits at 16 and the status register at 17. Alarm bytes and the control register read back exactly the 8 bits last written.
- R3: A match is evaluated only in a cycle where `sec_tick` is high. A field takes part only when bit 7 of its alarm byte is 1, and it then matches when bits 6:0 equal the live time field. Disabled fields are ignored. A match that persists without a tick produces no further event.
- R4: An alarm is armed only when its enable bit in the control register (bit 0 for alarm 0, bit 1 for alarm 1) is 1 and at least one of its field enables is 1. An unarmed alarm never sets its flag.
- R5: In latched mode (control bit 6 = 0), a match sets the alarm's flag. `irq_n` is low while any flag is set and returns high only when both flags are clear.
- R6: Writing the status register clears each flag whose data bit is 0. A data bit of 1 leaves that flag unchanged.
- R7: With control bit 7 = 1, a read of the status register returns the flags and then clears both. With control bit 7 = 0, reads leave the flags unchanged.
- R8: In periodic mode (control bit 6 = 1), each match sets the flag and drives `irq_n` low for exactly 4 clock cycles, starting on the clock edge that samples the tick. A later match restarts the pulse.
- R9: A match in the same cycle as a status read or write that would clear the flag leaves that flag set.
- R10: The status register returns alarm 0's flag in bit 0 and alarm 1's flag in bit 1, with bits 7:2 reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_tick | input | 1 | One-cycle strobe marking a new second of the live time |
| tm_sec | input | 7 | Live BCD seconds |
| tm_min | input | 7 | Live BCD minutes |
| tm_hour | input | 7 | Live BCD hours, including the format bit in bit 6 |
| tm_date | input | 7 | Live BCD day of month |
| tm_month | input | 7 | Live BCD month |
| tm_wday | input | 7 | Live day of week, 0 to 6 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; triggers auto-clear on the status address |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_n | output | 1 | Shared active-low alarm interrupt |

## Verification
The bench builds the block with its defaults: two alarms, a 4-cycle periodic pulse and a 5-bit address. With these values both alarms share the interrupt line, so the partial-clear case in latched mode can be reached directly. The full pulse width, the edge where it ends and a retrigger all fall within a handful of cycles. A table of time patterns against one alarm exercises enabled and disabled fields. Directed sequences then cover arming, auto-clear, clears that collide with a match, and matches held without a tick.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int FIELD_CNT   = 6;
  localparam int BYTE_W      = 8;
  localparam int TIME_W      = 7;
  localparam int ALM_STRIDE  = 8;
  localparam int CTRL_ADDR   = 16;
  localparam int STAT_ADDR   = 17;
  localparam int CTL_AUTO    = 7;
  localparam int CTL_PERIOD  = 6;
endpackage

// File: rtl/cal_alarm_set.sv
module cal_alarm_set
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BASE   = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BYTE_W-1:0]             wdata,
  input  logic [FIELD_CNT*TIME_W-1:0]   now_flat,
  input  logic                          alm_on,
  input  logic                          tick,
  output logic [FIELD_CNT*BYTE_W-1:0]   bytes_flat,
  output logic                          hit
);

  logic [FIELD_CNT-1:0] fld_en;
  logic [FIELD_CNT-1:0] fld_ok;

  for (genvar f = 0; f < FIELD_CNT; f++) begin : g_field
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] byte_d;
    logic              sel;

    assign sel = wr_en && (addr == ADDR_W'(BASE + f));

    always_comb begin
      byte_d = byte_q;
      if (sel) byte_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    byte_q <= '0;
      else if (sel)  byte_q <= byte_d;
    end

    assign fld_en[f] = byte_q[BYTE_W-1];
    assign fld_ok[f] = !fld_en[f] ||
                       (byte_q[TIME_W-1:0] == now_flat[f*TIME_W +: TIME_W]);
    assign bytes_flat[f*BYTE_W +: BYTE_W] = byte_q;
  end

  assign hit = tick && alm_on && (|fld_en) && (&fld_ok);

endmodule

// File: rtl/cal_alarm_ctrl.sv
module cal_alarm_ctrl
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int NUM_ALM = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic [NUM_ALM-1:0] hit,
  output logic [BYTE_W-1:0]  ctrl_q,
  output logic [NUM_ALM-1:0] flags_q
);

  logic               ctrl_sel;
  logic               stat_wr;
  logic               stat_rd_clr;
  logic [NUM_ALM-1:0] clr;
  logic [NUM_ALM-1:0] flags_d;
  logic [BYTE_W-1:0]  ctrl_d;

  always_comb begin
    ctrl_sel    = wr_en && (addr == ADDR_W'(CTRL_ADDR));
    stat_wr     = wr_en && (addr == ADDR_W'(STAT_ADDR));
    stat_rd_clr = rd_en && (addr == ADDR_W'(STAT_ADDR)) && ctrl_q[CTL_AUTO];
    clr         = '0;
    if (stat_rd_clr)  clr = '1;
    else if (stat_wr) clr = ~wdata[NUM_ALM-1:0];
    flags_d = (flags_q & ~clr) | hit;
    ctrl_d  = ctrl_sel ? wdata : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (ctrl_sel) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // R3: a flag only rises after a qualified match from an alarm set
  assert_flag_from_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q) & ~$past(hit)) == '0));

  // R6: a flag only drops after a register access
  assert_clear_by_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags_q) & ~flags_q) != '0) |-> $past(wr_en || rd_en));

endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq #(
  parameter int NUM_ALM   = 2,
  parameter int PULSE_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               periodic,
  input  logic               trigger,
  input  logic [NUM_ALM-1:0] flags,
  output logic               irq_n
);

  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (periodic && trigger) begin
      cnt_d  = CNT_W'(PULSE_CYC);
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign irq_n = periodic ? (cnt_q == '0) : !(|flags);

  assert_pulse_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(PULSE_CYC));

  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic && $past(periodic) && $past(trigger)) |-> !irq_n);

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int NUM_ALM   = 2,
  parameter int PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [6:0]        tm_sec,
  input  logic [6:0]        tm_min,
  input  logic [6:0]        tm_hour,
  input  logic [6:0]        tm_date,
  input  logic [6:0]        tm_month,
  input  logic [6:0]        tm_wday,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [4:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_n
);

  logic [1:0]                          rst_pipe;
  logic                                rst_sync_n;
  logic [FIELD_CNT*TIME_W-1:0]         now_flat;
  logic [NUM_ALM-1:0][FIELD_CNT*BYTE_W-1:0] alm_bytes;
  logic [NUM_ALM-1:0]                  hit;
  logic [BYTE_W-1:0]                   ctrl_q;
  logic [NUM_ALM-1:0]                  flags_q;
  logic [ADDR_W-1:0]                   addr;

  assign addr = ADDR_W'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign now_flat = {tm_wday, tm_month, tm_date, tm_hour, tm_min, tm_sec};

  for (genvar a = 0; a < NUM_ALM; a++) begin : g_alarm
    cal_alarm_set #(
      .ADDR_W (ADDR_W),
      .BASE   (a * ALM_STRIDE)
    ) set_i (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_en      (reg_wr),
      .addr       (addr),
      .wdata      (reg_wdata),
      .now_flat   (now_flat),
      .alm_on     (ctrl_q[a]),
      .tick       (sec_tick),
      .bytes_flat (alm_bytes[a]),
      .hit        (hit[a])
    );
  end

  cal_alarm_ctrl #(
    .ADDR_W  (ADDR_W),
    .NUM_ALM (NUM_ALM)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr),
    .rd_en   (reg_rd),
    .addr    (addr),
    .wdata   (reg_wdata),
    .hit     (hit),
    .ctrl_q  (ctrl_q),
    .flags_q (flags_q)
  );

  cal_alarm_irq #(
    .NUM_ALM   (NUM_ALM),
    .PULSE_CYC (PULSE_CYC)
  ) irq_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .periodic (ctrl_q[CTL_PERIOD]),
    .trigger  (|hit),
    .flags    (flags_q),
    .irq_n    (irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) reg_rdata = ctrl_q;
    if (addr == ADDR_W'(STAT_ADDR)) reg_rdata = BYTE_W'(flags_q);
    for (int a = 0; a < NUM_ALM; a++) begin
      for (int f = 0; f < FIELD_CNT; f++) begin
        if (addr == ADDR_W'(a * ALM_STRIDE + f))
          reg_rdata = alm_bytes[a][f*BYTE_W +: BYTE_W];
      end
    end
  end

  // R5: in latched mode the line stays low until software touches the registers
  assert_latched_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctrl_q[CTL_PERIOD] && $past(!ctrl_q[CTL_PERIOD]) && $past(!irq_n) &&
     !$past(reg_wr || reg_rd)) |-> !irq_n);

endmodule

// File: tb/cal_alarm_cmp_tb.sv
module cal_alarm_cmp_tb_top;

  logic       clk;
  logic       rst_n;
  logic       sec_tick;
  logic [6:0] tm_sec, tm_min, tm_hour, tm_date, tm_month, tm_wday;
  logic       reg_wr, reg_rd;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  cal_alarm_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
    .tm_date(tm_date), .tm_month(tm_month), .tm_wday(tm_wday),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {expect_flag0, sec, min, hour, date, month, wday}
  localparam logic [42:0] VEC [6] = '{
    {1'b1, 7'h30, 7'h15, 7'h08, 7'h01, 7'h01, 7'h00},
    {1'b0, 7'h31, 7'h15, 7'h08, 7'h01, 7'h01, 7'h00},
    {1'b0, 7'h30, 7'h16, 7'h08, 7'h01, 7'h01, 7'h00},
    {1'b1, 7'h30, 7'h15, 7'h23, 7'h01, 7'h01, 7'h00},
    {1'b1, 7'h30, 7'h15, 7'h08, 7'h31, 7'h12, 7'h06},
    {1'b0, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_time(input logic [41:0] t);
    {tm_sec, tm_min, tm_hour, tm_date, tm_month, tm_wday} = t;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  localparam logic [41:0] T_MATCH = {7'h30, 7'h15, 7'h08, 7'h01, 7'h01, 7'h00};
  localparam logic [41:0] T_NONE  = {7'h59, 7'h59, 7'h00, 7'h00, 7'h00, 7'h00};

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; sec_tick = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    set_time(T_NONE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #1 check("R1 irq_n", irq_n, 1);
    rd_reg(5'd17, d); check("R1 status", d, 0);
    rd_reg(5'd0,  d); check("R1 alarm byte", d, 0);
    rd_reg(5'd16, d); check("R1 control", d, 0);

    // R2 register map and readback
    wr_reg(5'd0, 8'hB0);
    wr_reg(5'd1, 8'h95);
    wr_reg(5'd2, 8'h08);
    wr_reg(5'd13, 8'hA5);
    rd_reg(5'd0, d);  check("R2 alarm0 sec", d, 8'hB0);
    rd_reg(5'd1, d);  check("R2 alarm0 min", d, 8'h95);
    rd_reg(5'd13, d); check("R2 alarm1 wday", d, 8'hA5);
    wr_reg(5'd13, 8'h00);
    wr_reg(5'd16, 8'h5A);
    rd_reg(5'd16, d); check("R2 control", d, 8'h5A);
    wr_reg(5'd16, 8'h00);

    // R4 alarm enable off: no flag
    set_time(T_MATCH);
    tick();
    rd_reg(5'd17, d); check("R4 disabled alarm0", d, 0);
    // R4 alarm1 enabled but no field enables
    wr_reg(5'd16, 8'h02);
    tick();
    rd_reg(5'd17, d); check("R4 no field enable", d, 0);

    // R3 match without tick does nothing
    wr_reg(5'd16, 8'h01);
    repeat (10) @(negedge clk);
    #1 check("R3 no tick irq", irq_n, 1);
    rd_reg(5'd17, d); check("R3 no tick status", d, 0);
    tick();
    check("R5 irq low on match", irq_n, 0);
    rd_reg(5'd17, d); check("R10 status flag0", d, 8'h01);
    rd_reg(5'd17, d); check("R7 no auto-clear", d, 8'h01);
    wr_reg(5'd17, 8'h00);
    #1 check("R6 clear irq", irq_n, 1);

    // R3 table of time patterns against alarm0
    foreach (VEC[i]) begin
      set_time(VEC[i][41:0]);
      tick();
      rd_reg(5'd17, d);
      check($sformatf("R3 vector %0d flag0", i), d[0], VEC[i][42]);
      check($sformatf("R10 vector %0d upper", i), d[7:1], 0);
      wr_reg(5'd17, 8'h00);
    end

    // R5 / R6 both alarms share the line
    wr_reg(5'd9, 8'h95);
    wr_reg(5'd16, 8'h03);
    set_time(T_MATCH);
    tick();
    rd_reg(5'd17, d); check("R10 both flags", d, 8'h03);
    wr_reg(5'd17, 8'h02);
    rd_reg(5'd17, d); check("R6 write one keeps flag1", d, 8'h02);
    #1 check("R5 irq low with flag1", irq_n, 0);
    wr_reg(5'd17, 8'h00);
    #1 check("R5 irq high both clear", irq_n, 1);
    wr_reg(5'd9, 8'h00);

    // R7 auto-clear on status read
    wr_reg(5'd16, 8'h81);
    tick();
    rd_reg(5'd17, d); check("R7 read returns flag", d, 8'h01);
    rd_reg(5'd17, d); check("R7 auto-cleared", d, 0);
    #1 check("R7 irq high", irq_n, 1);

    // R9 match coinciding with an auto-clearing read
    @(negedge clk);
    sec_tick = 1'b1; reg_rd = 1'b1; reg_addr = 5'd17;
    @(negedge clk);
    sec_tick = 1'b0; reg_rd = 1'b0;
    rd_reg(5'd17, d); check("R9 read collision keeps flag", d, 8'h01);
    // R9 match coinciding with a clearing write
    wr_reg(5'd16, 8'h01);
    @(negedge clk);
    sec_tick = 1'b1; reg_wr = 1'b1; reg_addr = 5'd17; reg_wdata = 8'h00;
    @(negedge clk);
    sec_tick = 1'b0; reg_wr = 1'b0;
    rd_reg(5'd17, d); check("R9 write collision keeps flag", d, 8'h01);
    wr_reg(5'd17, 8'h00);

    // R8 periodic pulse
    wr_reg(5'd16, 8'h41);
    tick();
    check("R8 pulse cycle 1", irq_n, 0);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk); #1;
      check($sformatf("R8 pulse cycle %0d", k), irq_n, 0);
    end
    @(negedge clk); #1;
    check("R8 pulse ends", irq_n, 1);
    rd_reg(5'd17, d); check("R8 flag set", d, 8'h01);
    tick();
    check("R8 retrigger", irq_n, 0);
    repeat (10) @(negedge clk);
    #1 check("R3 held match one event", irq_n, 1);

    done = 1;
    summary();
    $finish;
  end

endmodule